// File: doc/BRIEF.md
# Console System Bus Address Decoder

This block sits between a 16-bit big-endian processor with a 24-bit byte address and the targets on its bus. Each request is sorted into one of four regions: cartridge space, a small peripheral register window, the video-controller port window and work RAM. The work RAM is held inside the block as byte-wide storage. Any address outside these four regions is a hole: it reads as zero and ignores writes.

The cartridge and the video controller only accept 16-bit words. For a byte access to either of them, the block issues a word access at the even address. On a read it picks the right byte lane from the returned word. On a write it copies the byte into both halves of the word. The peripheral window decodes even offsets to a data register and a control register for each of `NPORTS` ports (two pads and one extension port by default). Byte writes to those registers travel in the low lane.

Work RAM is `2**RAM_AW` bytes and is indexed by the low `RAM_AW` address bits only, so it repeats across its region. The full system uses `RAM_AW = 16` (64 KiB). The default of 12 keeps the elaborated array small. Each external target gets a single-cycle strobe in the request cycle. Every read returns its data exactly one cycle later, whatever its source.

Top module: `sysbus_decode`

## Requirements
- R1: An address below 0x400000 strobes `cart_req` in the request cycle. The forwarded address has bit 0 cleared, and word accesses pass read and write data unchanged.
- R2: An address from 0xC00000 to 0xDFFFFF strobes `vid_req` with the same address and word rules as R1.
- R3: Addresses in 0x400000–0xA0FFFF and 0xA10020–0xBFFFFF strobe no target. Reads there return 0x0000 and writes there change no state.
- R4: A byte read from cartridge or video returns the upper half of the fetched word when address bit 0 is 0, and the lower half when bit 0 is 1. The byte is returned in `cpu_rdata[7:0]` with `cpu_rdata[15:8]` at zero.
- R5: A byte write to cartridge or video drives the write data as {byte, byte}.
- R6: Work RAM (0xE00000 and up) is indexed by address bits [RAM_AW-1:0] only, so addresses that differ in higher bits reach the same byte.
- R7: A word RAM access is big-endian. The byte at the index is bits [15:8] and the byte at index+1 is bits [7:0]. The index+1 wraps modulo the RAM size, and odd addresses are allowed.
- R8: A byte RAM access touches one byte. A byte read returns it in `cpu_rdata[7:0]` with the upper half at zero.
- R9: In 0xA10000–0xA1001F, offset bits [4:1] = p+1 select the data register of port p, and bits [4:1] = NPORTS+p+1 select its control register. The strobe is `io_req[p]` (one-hot), with `io_ctrl` at 1 for the control register.
- R10: Any other offset inside the peripheral window strobes no port, reads 0x0000 and drops writes.
- R11: A byte write to a port register drives {8'h00, byte}. A word write passes unchanged. A byte read returns the low half of the register zero-extended, and a word read returns it whole.
- R12: `cpu_rvalid` is high exactly in the cycle after a read request, carrying that read's data. A new request may be issued in that same cycle.
- R13: After reset, and in every cycle with `cpu_rvalid` low, `cpu_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 16 | Write data; byte writes use bits [7:0] |
| cpu_rvalid | output | 1 | Read data valid (cycle after the read request) |
| cpu_rdata | output | 16 | Read data |
| cart_req | output | 1 | Cartridge strobe |
| cart_we | output | 1 | Cartridge write enable |
| cart_addr | output | 24 | Cartridge word address (bit 0 zero) |
| cart_wdata | output | 16 | Cartridge write word |
| cart_rdata | input | 16 | Cartridge read word, valid the cycle after the strobe |
| vid_req | output | 1 | Video-controller strobe |
| vid_we | output | 1 | Video-controller write enable |
| vid_addr | output | 24 | Video-controller word address (bit 0 zero) |
| vid_wdata | output | 16 | Video-controller write word |
| vid_rdata | input | 16 | Video-controller read word, valid the cycle after the strobe |
| io_req | output | NPORTS | One-hot peripheral port strobe |
| io_ctrl | output | 1 | 1 = control register, 0 = data register |
| io_we | output | 1 | Peripheral write enable |
| io_wdata | output | 16 | Peripheral write data |
| io_rdata | input | NPORTS*16 | Per-port read data, port p in bits [16p+15:16p], valid the cycle after the strobe |

## Verification
Two things can share a clock cycle: the returned result of a read, and the strobe or RAM write of the next request. The bench provokes this in two ways. It follows a RAM word read at once by a word write to the same address. It also follows a cartridge read at once by a peripheral control write. In the overlap cycle it checks that the read result still carries the old RAM contents or the cartridge word, and that the new strobe carries the correct port, register and data. A later read then shows the RAM write did land. All other expected values come from a byte-array model and address arithmetic in the bench. These are swept across every region edge, every offset of the peripheral window, both lanes, and the RAM wrap at the top index.

// File: rtl/sysbus_pkg.sv
`timescale 1ns/1ps
package sysbus_pkg;
   localparam int unsigned ADDR_W = 24;
   localparam int unsigned DATA_W = 16;

   localparam logic [ADDR_W-1:0] CART_LIMIT = 24'h40_0000;
   localparam logic [ADDR_W-1:0] IO_FIRST   = 24'hA1_0000;
   localparam logic [ADDR_W-1:0] IO_LIMIT   = 24'hA1_0020;
   localparam logic [ADDR_W-1:0] VID_FIRST  = 24'hC0_0000;
   localparam logic [ADDR_W-1:0] RAM_FIRST  = 24'hE0_0000;

   typedef enum logic [2:0] {
      RG_NONE = 3'd0,
      RG_CART = 3'd1,
      RG_IO   = 3'd2,
      RG_VID  = 3'd3,
      RG_RAM  = 3'd4
   } region_e;

   function automatic region_e region_of(input logic [ADDR_W-1:0] a);
      if (a < CART_LIMIT) return RG_CART;
      if (a >= RAM_FIRST) return RG_RAM;
      if (a >= VID_FIRST) return RG_VID;
      if (a >= IO_FIRST && a < IO_LIMIT) return RG_IO;
      return RG_NONE;
   endfunction
endpackage

// File: rtl/sysbus_region_dec.sv
`timescale 1ns/1ps
module sysbus_region_dec
   import sysbus_pkg::*;
#(
   parameter int unsigned NPORTS = 3,
   localparam int unsigned PW = $clog2(NPORTS)
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic              io_hit,
   output logic [PW-1:0]     io_port,
   output logic              io_ctrl
);
   generate
      if (NPORTS < 2 || 2 * NPORTS > 15) begin : g_bad_ports
         $error("sysbus_region_dec: NPORTS must lie in 2..7");
      end
   endgenerate

   logic [3:0] off;
   assign off = addr[4:1];

   always_comb begin
      region  = region_of(addr);
      io_hit  = 1'b0;
      io_port = '0;
      io_ctrl = 1'b0;
      for (int p = 0; p < NPORTS; p++) begin
         if (off == 4'(p + 1)) begin
            io_hit  = 1'b1;
            io_port = PW'(p);
            io_ctrl = 1'b0;
         end
         if (off == 4'(p + 1 + NPORTS)) begin
            io_hit  = 1'b1;
            io_port = PW'(p);
            io_ctrl = 1'b1;
         end
      end
      if (region != RG_IO) begin
         io_hit  = 1'b0;
         io_port = '0;
         io_ctrl = 1'b0;
      end
   end
endmodule

// File: rtl/sysbus_ram_bank.sv
`timescale 1ns/1ps
module sysbus_ram_bank #(
   parameter int unsigned AW = 11,
   localparam int unsigned DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic          re,
   input  logic [AW-1:0] idx,
   input  logic [7:0]    wdata,
   output logic [7:0]    q
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
      if (re) q <= mem[idx];
   end
endmodule

// File: rtl/sysbus_ram.sv
`timescale 1ns/1ps
module sysbus_ram #(
   parameter int unsigned AW = 12,
   localparam int unsigned BW = AW - 1
) (
   input  logic          clk,
   input  logic          acc,
   input  logic          we,
   input  logic          word,
   input  logic [AW-1:0] idx,
   input  logic [15:0]   wdata,
   output logic [15:0]   q
);
   generate
      if (AW < 2) begin : g_bad_aw
         $error("sysbus_ram: AW must be at least 2");
      end
   endgenerate

   logic [BW-1:0] w_lo, w_hi;
   logic          odd, re;
   logic [BW-1:0] b_idx [2];
   logic          b_we  [2];
   logic [7:0]    b_wd  [2];
   logic [7:0]    b_q   [2];
   logic          q_odd, q_word;

   assign w_lo = idx[AW-1:1];
   assign w_hi = w_lo + 1'b1;
   assign odd  = idx[0];
   assign re   = acc && !we;

   // bank 0 holds even bytes, bank 1 holds odd bytes
   always_comb begin
      b_idx[0] = odd ? w_hi : w_lo;
      b_idx[1] = w_lo;
      b_we[0]  = acc && we && (word || !odd);
      b_we[1]  = acc && we && (word || odd);
      if (word) begin
         b_wd[0] = odd ? wdata[7:0]  : wdata[15:8];
         b_wd[1] = odd ? wdata[15:8] : wdata[7:0];
      end else begin
         b_wd[0] = wdata[7:0];
         b_wd[1] = wdata[7:0];
      end
   end

   generate
      for (genvar b = 0; b < 2; b++) begin : g_bank
         sysbus_ram_bank #(.AW(BW)) u_bank (
            .clk   (clk),
            .we    (b_we[b]),
            .re    (re),
            .idx   (b_idx[b]),
            .wdata (b_wd[b]),
            .q     (b_q[b])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (re) begin
         q_odd  <= odd;
         q_word <= word;
      end
   end

   always_comb begin
      if (q_word) q = q_odd ? {b_q[1], b_q[0]} : {b_q[0], b_q[1]};
      else        q = {8'h00, q_odd ? b_q[1] : b_q[0]};
   end
endmodule

// File: rtl/sysbus_decode.sv
`timescale 1ns/1ps
module sysbus_decode
   import sysbus_pkg::*;
#(
   parameter int unsigned NPORTS = 3,
   parameter int unsigned RAM_AW = 12,
   localparam int unsigned PW = $clog2(NPORTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cpu_req,
   input  logic                 cpu_we,
   input  logic                 cpu_word,
   input  logic [23:0]          cpu_addr,
   input  logic [15:0]          cpu_wdata,
   output logic                 cpu_rvalid,
   output logic [15:0]          cpu_rdata,
   output logic                 cart_req,
   output logic                 cart_we,
   output logic [23:0]          cart_addr,
   output logic [15:0]          cart_wdata,
   input  logic [15:0]          cart_rdata,
   output logic                 vid_req,
   output logic                 vid_we,
   output logic [23:0]          vid_addr,
   output logic [15:0]          vid_wdata,
   input  logic [15:0]          vid_rdata,
   output logic [NPORTS-1:0]    io_req,
   output logic                 io_ctrl,
   output logic                 io_we,
   output logic [15:0]          io_wdata,
   input  logic [NPORTS*16-1:0] io_rdata
);
   generate
      if (RAM_AW < 2 || RAM_AW > 16) begin : g_bad_ram
         $error("sysbus_decode: RAM_AW must lie in 2..16");
      end
   endgenerate

   region_e       region;
   logic          io_hit;
   logic [PW-1:0] io_port;
   logic          dec_ctrl;

   sysbus_region_dec #(.NPORTS(NPORTS)) u_dec (
      .addr    (cpu_addr),
      .region  (region),
      .io_hit  (io_hit),
      .io_port (io_port),
      .io_ctrl (dec_ctrl)
   );

   // request side: strobes and lane shaping
   logic [15:0] dup_wdata;
   assign dup_wdata  = cpu_word ? cpu_wdata : {cpu_wdata[7:0], cpu_wdata[7:0]};

   assign cart_req   = cpu_req && (region == RG_CART);
   assign cart_we    = cpu_we;
   assign cart_addr  = {cpu_addr[23:1], 1'b0};
   assign cart_wdata = dup_wdata;

   assign vid_req    = cpu_req && (region == RG_VID);
   assign vid_we     = cpu_we;
   assign vid_addr   = {cpu_addr[23:1], 1'b0};
   assign vid_wdata  = dup_wdata;

   assign io_ctrl    = dec_ctrl;
   assign io_we      = cpu_we;
   assign io_wdata   = cpu_word ? cpu_wdata : {8'h00, cpu_wdata[7:0]};

   logic [15:0] io_word [NPORTS];
   generate
      for (genvar p = 0; p < NPORTS; p++) begin : g_port
         assign io_req[p]  = cpu_req && io_hit && (io_port == PW'(p));
         assign io_word[p] = io_rdata[p*16 +: 16];
      end
   endgenerate

   // work RAM
   logic [15:0] ram_q;
   sysbus_ram #(.AW(RAM_AW)) u_ram (
      .clk   (clk),
      .acc   (cpu_req && (region == RG_RAM)),
      .we    (cpu_we),
      .word  (cpu_word),
      .idx   (cpu_addr[RAM_AW-1:0]),
      .wdata (cpu_wdata),
      .q     (ram_q)
   );

   // response side: one registered stage, then the lane mux
   logic          rsp_valid, rsp_word, rsp_odd, rsp_iohit;
   region_e       rsp_region;
   logic [PW-1:0] rsp_port;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_word   <= 1'b0;
         rsp_odd    <= 1'b0;
         rsp_iohit  <= 1'b0;
         rsp_region <= RG_NONE;
         rsp_port   <= '0;
      end else begin
         rsp_valid  <= cpu_req && !cpu_we;
         rsp_word   <= cpu_word;
         rsp_odd    <= cpu_addr[0];
         rsp_iohit  <= io_hit;
         rsp_region <= region;
         rsp_port   <= io_port;
      end
   end

   logic [15:0] ext_w, rd_mux;
   always_comb begin
      case (rsp_region)
         RG_CART: ext_w = cart_rdata;
         RG_VID:  ext_w = vid_rdata;
         RG_IO:   ext_w = rsp_iohit ? io_word[rsp_port] : 16'h0000;
         default: ext_w = 16'h0000;
      endcase
      if (rsp_region == RG_RAM) rd_mux = ram_q;
      else if (rsp_word)        rd_mux = ext_w;
      else if (rsp_region == RG_IO) rd_mux = {8'h00, ext_w[7:0]};
      else rd_mux = {8'h00, rsp_odd ? ext_w[7:0] : ext_w[15:8]};
   end

   assign cpu_rvalid = rsp_valid;
   assign cpu_rdata  = rsp_valid ? rd_mux : 16'h0000;

   // ---------------- assertions ----------------
   a_r1_cart_window: assert property (@(posedge clk) disable iff (!rst_n)
      cart_req |-> (cpu_req && cpu_addr < CART_LIMIT && !cart_addr[0]));

   a_r2_vid_window: assert property (@(posedge clk) disable iff (!rst_n)
      vid_req |-> (cpu_addr >= VID_FIRST && cpu_addr < RAM_FIRST && !vid_addr[0]));

   a_r3_hole_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && ((cpu_addr >= CART_LIMIT && cpu_addr < IO_FIRST) ||
                   (cpu_addr >= IO_LIMIT && cpu_addr < VID_FIRST)))
      |-> (!cart_req && !vid_req && io_req == '0));

   a_r5_byte_dup: assert property (@(posedge clk) disable iff (!rst_n)
      (cart_req && cart_we && !cpu_word) |-> (cart_wdata[15:8] == cpu_wdata[7:0]
                                              && cart_wdata[7:0] == cpu_wdata[7:0]));

   a_r8_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rvalid && !rsp_word) |-> (cpu_rdata[15:8] == 8'h00));

   a_r9_port_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cart_req, vid_req, io_req}));

   a_r10_io_window: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req != '0) |-> (cpu_addr >= IO_FIRST && cpu_addr < IO_LIMIT));

   a_r11_io_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
      ((io_req != '0) && io_we && !cpu_word) |-> (io_wdata[15:8] == 8'h00));

   a_r12_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we) |=> cpu_rvalid);

   a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_req && !cpu_we) |=> !cpu_rvalid);

   a_r13_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rvalid |-> (cpu_rdata == 16'h0000));
endmodule

// File: tb/sysbus_decode_tb.sv
`timescale 1ns/1ps
module sysbus_decode_tb_top;
   localparam int NP     = 3;
   localparam int RAW    = 12;
   localparam int RDEPTH = 1 << RAW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_word = 1'b0;
   logic [23:0] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic cpu_rvalid;
   logic [15:0] cpu_rdata;
   logic cart_req, cart_we, vid_req, vid_we, io_ctrl, io_we;
   logic [23:0] cart_addr, vid_addr;
   logic [15:0] cart_wdata, vid_wdata, io_wdata;
   logic [15:0] cart_rdata = '0, vid_rdata = '0;
   logic [NP-1:0] io_req;
   logic [NP*16-1:0] io_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] mdl [RDEPTH];

   always #10 clk = ~clk;

   sysbus_decode #(.NPORTS(NP), .RAM_AW(RAW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_word(cpu_word),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
      .cart_req(cart_req), .cart_we(cart_we), .cart_addr(cart_addr),
      .cart_wdata(cart_wdata), .cart_rdata(cart_rdata),
      .vid_req(vid_req), .vid_we(vid_we), .vid_addr(vid_addr),
      .vid_wdata(vid_wdata), .vid_rdata(vid_rdata),
      .io_req(io_req), .io_ctrl(io_ctrl), .io_we(io_we),
      .io_wdata(io_wdata), .io_rdata(io_rdata)
   );

   function automatic logic [15:0] cart_val(input logic [23:0] a);
      return a[16:1] ^ 16'h5A3C;
   endfunction
   function automatic logic [15:0] vid_val(input logic [23:0] a);
      return {a[8:1], a[16:9]} ^ 16'h0FF0;
   endfunction
   function automatic logic [15:0] io_val(input int p, input logic c);
      return 16'hD003 | (c ? 16'h0800 : 16'h0000) | 16'(p << 4);
   endfunction

   // external targets answer in the cycle after their strobe
   always @(posedge clk) begin
      if (cart_req && !cart_we) cart_rdata <= cart_val(cart_addr);
      if (vid_req && !vid_we) vid_rdata <= vid_val(vid_addr);
      for (int p = 0; p < NP; p++)
         if (io_req[p] && !io_we) io_rdata[p*16 +: 16] <= io_val(p, io_ctrl);
   end

   // 0 hole, 1 cart, 2 io, 3 video, 4 ram
   function automatic int reg_of(input logic [23:0] a);
      if (a[23:22] == 2'b00) return 1;
      if (a[23:21] == 3'b111) return 4;
      if (a[23:21] == 3'b110) return 3;
      if (a[23:5] == 19'h50800) return 2;
      return 0;
   endfunction
   function automatic int io_port_of(input logic [23:0] a);
      int off = int'(a[4:1]);
      if (off >= 1 && off <= NP) return off - 1;
      if (off >= NP + 1 && off <= 2 * NP) return off - NP - 1;
      return -1;
   endfunction
   function automatic string tag_of(input logic we, input logic word, input logic [23:0] a);
      case (reg_of(a))
         1: return word ? "R1" : (we ? "R5" : "R4");
         3: return word ? "R2" : (we ? "R5" : "R4");
         2: return (io_port_of(a) < 0) ? "R10" : (word ? "R9" : "R11");
         4: return word ? "R7" : "R8";
         default: return "R3";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp,
                      input string what);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   function automatic logic [15:0] exp_read(input logic word, input logic [23:0] a);
      int rg = reg_of(a);
      int pt = io_port_of(a);
      int i  = int'(a[RAW-1:0]);
      logic [15:0] w;
      case (rg)
         1: begin
            w = cart_val({a[23:1], 1'b0});
            return word ? w : {8'h00, a[0] ? w[7:0] : w[15:8]};
         end
         3: begin
            w = vid_val({a[23:1], 1'b0});
            return word ? w : {8'h00, a[0] ? w[7:0] : w[15:8]};
         end
         2: begin
            if (pt < 0) return 16'h0000;
            w = io_val(pt, a[4:1] > 4'(NP));
            return word ? w : {8'h00, w[7:0]};
         end
         4: return word ? {mdl[i], mdl[(i + 1) % RDEPTH]} : {8'h00, mdl[i]};
         default: return 16'h0000;
      endcase
   endfunction

   task automatic model_write(input logic word, input logic [23:0] a, input logic [15:0] wd);
      int i = int'(a[RAW-1:0]);
      if (reg_of(a) != 4) return;
      if (word) begin
         mdl[i] = wd[15:8];
         mdl[(i + 1) % RDEPTH] = wd[7:0];
      end else begin
         mdl[i] = wd[7:0];
      end
   endtask

   // drive the request cycle's strobe checks
   task automatic chk_strobes(input string tag, input logic we, input logic word,
                              input logic [23:0] a, input logic [15:0] wd);
      int rg = reg_of(a);
      int pt = io_port_of(a);
      logic [NP-1:0] exp_io;
      logic [15:0] dup, iow;
      exp_io = (rg == 2 && pt >= 0) ? NP'(1 << pt) : '0;
      dup = word ? wd : {wd[7:0], wd[7:0]};
      iow = word ? wd : {8'h00, wd[7:0]};
      chk(tag, {cart_req, vid_req, io_req}, {rg == 1, rg == 3, exp_io}, "strobes");
      if (rg == 1) chk(tag, {cart_we, cart_addr, cart_wdata}, {we, a[23:1], 1'b0, dup}, "cart cmd");
      if (rg == 3) chk(tag, {vid_we, vid_addr, vid_wdata}, {we, a[23:1], 1'b0, dup}, "video cmd");
      if (exp_io != '0) chk(tag, {io_we, io_ctrl, io_wdata}, {we, a[4:1] > 4'(NP), iow}, "port cmd");
   endtask

   task automatic acc_t(input logic we, input logic word, input logic [23:0] a,
                        input logic [15:0] wd, input string tag);
      logic [15:0] exp;
      exp = exp_read(word, a);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_word = word; cpu_addr = a; cpu_wdata = wd;
      #1;
      chk_strobes(tag, we, word, a, wd);
      @(negedge clk);
      cpu_req = 1'b0;
      #1;
      chk("R12", cpu_rvalid, !we, "rvalid");
      if (!we) chk(tag, cpu_rdata, exp, "rdata");
      else     chk("R13", cpu_rdata, 16'h0000, "idle rdata");
      if (we) model_write(word, a, wd);
   endtask

   task automatic acc(input logic we, input logic word, input logic [23:0] a,
                      input logic [15:0] wd);
      acc_t(we, word, a, wd, tag_of(we, word, a));
   endtask

   initial begin
      #(20 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic [23:0] pts [22];
      logic [15:0] old_w;
      pts = '{24'h000000, 24'h000001, 24'h3FFFFE, 24'h3FFFFF, 24'h400000, 24'h9FFFFF,
              24'hA00000, 24'hA0FFFF, 24'hA10020, 24'hBFFFFF, 24'hC00000, 24'hC00001,
              24'hDFFFFE, 24'hDFFFFF, 24'hE00000, 24'hE00001, 24'hEFFFFF, 24'hFFFFFE,
              24'hFFFFFF, 24'h123457, 24'hA10021, 24'hF01234};
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R13", {cpu_rvalid, cpu_rdata}, 17'h0, "after reset");
      chk("R13", {cart_req, vid_req, io_req}, '0, "strobes idle");

      // R7: fill RAM with word writes so every byte is known
      for (int i = 0; i < RDEPTH / 2; i++)
         acc_t(1'b1, 1'b1, 24'hE00000 + 24'(2 * i), 16'(i * 37) ^ 16'hA55A, "R7");

      // region edges, both lanes, both widths; alias read catches stray RAM writes (R3)
      foreach (pts[k]) begin
         logic [23:0] a = pts[k];
         acc(1'b0, 1'b0, a, 16'h0);
         acc(1'b0, 1'b1, a, 16'h0);
         acc(1'b1, 1'b0, a, {8'hEE, a[7:0] ^ 8'h3C});
         acc(1'b1, 1'b1, a, {a[7:0], ~a[7:0]});
         acc(1'b0, 1'b1, a, 16'h0);
         acc(1'b0, 1'b0, a, 16'h0);
         acc_t(1'b0, 1'b1, {8'hE0, a[15:0]}, 16'h0, (reg_of(a) == 0) ? "R3" : "R6");
      end

      // every offset of the peripheral window (R9, R10, R11)
      for (int o = 0; o < 32; o++) begin
         logic [23:0] a = 24'hA10000 + 24'(o);
         acc(1'b0, 1'b0, a, 16'h0);
         acc(1'b1, 1'b0, a, {8'h99, 8'(o) ^ 8'h5A});
         if (o % 2 == 0) begin
            acc(1'b0, 1'b1, a, 16'h0);
            acc(1'b1, 1'b1, a, 16'(o) * 16'h0111);
         end
      end

      // R6 mirroring and R7 wrap at the top index
      acc_t(1'b1, 1'b0, 24'hE00123, 16'h00C7, "R6");
      acc_t(1'b0, 1'b0, 24'hE01123, 16'h0, "R6");
      acc_t(1'b0, 1'b0, 24'hFFF123, 16'h0, "R6");
      acc_t(1'b1, 1'b1, 24'hE00FFF, 16'h8143, "R7");
      acc_t(1'b0, 1'b1, 24'hF7FFFF, 16'h0, "R7");
      acc_t(1'b0, 1'b0, 24'hE00000, 16'h0, "R6");

      // R12 overlap: RAM read result shares a cycle with a write to the same word
      old_w = exp_read(1'b1, 24'hE00040);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_word = 1'b1; cpu_addr = 24'hE00040;
      @(negedge clk);
      cpu_we = 1'b1; cpu_wdata = 16'hBEEF;
      #1;
      chk("R12", {cpu_rvalid, cpu_rdata}, {1'b1, old_w}, "read beside write");
      @(negedge clk);
      cpu_req = 1'b0;
      #1;
      chk("R12", cpu_rvalid, 1'b0, "write gives no rvalid");
      model_write(1'b1, 24'hE00040, 16'hBEEF);
      acc_t(1'b0, 1'b1, 24'hE00040, 16'h0, "R12");

      // R12 overlap: cartridge read result beside a port control write
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_word = 1'b1; cpu_addr = 24'h001234;
      @(negedge clk);
      cpu_we = 1'b1; cpu_addr = 24'hA10008; cpu_wdata = 16'h1357;
      #1;
      chk("R12", {cpu_rvalid, cpu_rdata}, {1'b1, cart_val(24'h001234)}, "cart read beside port write");
      chk("R9", {io_req, io_ctrl, io_we, io_wdata}, {3'b001, 1'b1, 1'b1, 16'h1357}, "port strobe in overlap");
      @(negedge clk);
      cpu_req = 1'b0;
      #1;
      chk("R13", cpu_rdata, 16'h0000, "idle after write");

      report();
   end
endmodule